// File: doc/BRIEF.md
# Bitwise Operation Scope Dispatcher

The dispatcher sits between a command decoder and the banks of a resistive main memory that can compute bitwise results on whole rows. A request names two source rows and a destination row. The operation comes from a small mode register that is written by command. The dispatcher reads the chip, bank and subarray fields of the two sources and picks one of three execution paths.

When both sources share a subarray, the dispatcher issues one sense command that opens both rows at once. The sensing path returns the combined word. When the sources sit in different subarrays of one bank, the row-level staging buffer holds the first operand. The second operand arrives on the data line, and gate logic merges the two into the buffer. When the sources sit in different banks of one chip, the I/O-level staging buffer does the same job.

The result is always written to the destination row. A pair that names the same row, or that spans two chips, is refused with a one-cycle error pulse and causes no memory traffic. Inversion reads only the first source, so it always runs on the sensing path, and its second address plays no part.

Top module: `bwsd_scope_dispatch`

## Requirements
- R1: After reset, busy, done and err are low, the scope output is 0, and the operation mode is AND.
- R2: The mode encoding is AND=0, OR=1, XOR=2, INV=3. The mode in force when a request is accepted is the one executed.
- R3: Addresses are {chip, bank, subarray, row}, with chip in the top bits and row in the bottom bits. A two-operand pair in one subarray on different rows uses scope 0. It issues exactly one sense command and no row reads.
- R4: A two-operand pair in different subarrays of one bank uses scope 1. A pair in different banks of one chip uses scope 2. Either scope reads the first source, then the second, and then merges them.
- R5: A two-operand pair with equal addresses, or with different chip fields, pulses err for one cycle after the request. Busy stays low, and no sense, read or write is issued.
- R6: The word written to the destination row equals the selected operation applied to the two source words.
- R7: INV writes the complement of the first source. It never reads the second source, and it is never refused, whatever the second address is.
- R8: Busy is high from the cycle after acceptance through the write cycle. Requests and mode writes that arrive while busy leave the operation in flight unchanged. A request that arrives while busy raises no err.
- R9: done is high for exactly the one cycle in which the write is issued. That cycle is the 3rd busy cycle for scope 0 and the 4th busy cycle for scopes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Writes the operation mode register |
| mode_op | input | 2 | New operation code |
| req_valid | input | 1 | Request strobe; taken only when idle |
| req_src_a | input | ADDR_W | First source row address |
| req_src_b | input | ADDR_W | Second source row address |
| req_dst | input | ADDR_W | Destination row address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Write-back cycle of the current operation |
| err | output | 1 | Request refused (one cycle) |
| scope | output | 2 | Path of the accepted request: 0 subarray, 1 bank, 2 chip |
| sense_en | output | 1 | Multi-row sense command |
| sense_op | output | 2 | Operation applied by the sense path |
| sense_row_a | output | ADDR_W | First row opened |
| sense_row_b | output | ADDR_W | Second row opened |
| sense_data | input | DATA_W | Sense result, valid the cycle after sense_en |
| rd_en | output | 1 | Row read onto the data line |
| rd_addr | output | ADDR_W | Row read address |
| rd_data | input | DATA_W | Data line, valid the cycle after rd_en |
| wr_en | output | 1 | Destination row write |
| wr_addr | output | ADDR_W | Destination address |
| wr_data | output | DATA_W | Result word |

## Verification
If the classification is wrong, it shows at once, in the first busy cycle. The scope value is wrong, and so is the type of command issued: a sense command instead of row reads, or a refusal instead of busy. If the sequencer state is wrong, the done pulse moves away from the 3rd or 4th busy cycle. Either the read count or the latency then differs. If the staging buffer holds stale data or uses the wrong operation, the written word is wrong four cycles after the request. The same word can be read back from the destination row one cycle later.

// File: rtl/bwsd_pkg.sv
package bwsd_pkg;

   typedef enum logic [1:0] {
      OP_AND = 2'd0,
      OP_OR  = 2'd1,
      OP_XOR = 2'd2,
      OP_INV = 2'd3
   } bw_op_e;

   typedef enum logic [1:0] {
      SCOPE_ARRAY    = 2'd0,
      SCOPE_SUBARRAY = 2'd1,
      SCOPE_BANK     = 2'd2,
      SCOPE_NONE     = 2'd3
   } scope_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SENSE,
      ST_CAPT,
      ST_FETCH_A,
      ST_FETCH_B,
      ST_MERGE,
      ST_WRITE
   } seq_e;

endpackage

// File: rtl/bwsd_classify.sv
module bwsd_classify
   import bwsd_pkg::*;
#(
   parameter int CHIP_W = 1,
   parameter int BANK_W = 2,
   parameter int SUB_W  = 2,
   parameter int ROW_W  = 3,
   localparam int ADDR_W = CHIP_W + BANK_W + SUB_W + ROW_W
) (
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] src_a,
   input  logic [ADDR_W-1:0] src_b,
   output logic [1:0]        scope
);
   localparam int SUB_LO  = ROW_W;
   localparam int BANK_LO = ROW_W + SUB_W;
   localparam int CHIP_LO = ROW_W + SUB_W + BANK_W;

   logic same_chip, same_bank, same_sub, same_row_all;

   assign same_chip    = src_a[ADDR_W-1:CHIP_LO] == src_b[ADDR_W-1:CHIP_LO];
   assign same_bank    = src_a[CHIP_LO-1:BANK_LO] == src_b[CHIP_LO-1:BANK_LO];
   assign same_sub     = src_a[BANK_LO-1:SUB_LO] == src_b[BANK_LO-1:SUB_LO];
   assign same_row_all = src_a == src_b;

   always_comb begin
      if (op == OP_INV)             scope = SCOPE_ARRAY;
      else if (!same_chip)          scope = SCOPE_NONE;
      else if (same_row_all)        scope = SCOPE_NONE;
      else if (!same_bank)          scope = SCOPE_BANK;
      else if (!same_sub)           scope = SCOPE_SUBARRAY;
      else                          scope = SCOPE_ARRAY;
   end
endmodule

// File: rtl/bwsd_stage_buf.sv
module bwsd_stage_buf
   import bwsd_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              merge,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] gate_out;

   always_comb begin
      case (op)
         OP_AND:  gate_out = q & bus_in;
         OP_OR:   gate_out = q | bus_in;
         OP_XOR:  gate_out = q ^ bus_in;
         default: gate_out = ~q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= bus_in;
      else if (merge) q <= gate_out;
   end
endmodule

// File: rtl/bwsd_scope_dispatch.sv
module bwsd_scope_dispatch
   import bwsd_pkg::*;
#(
   parameter int CHIP_W = 1,
   parameter int BANK_W = 2,
   parameter int SUB_W  = 2,
   parameter int ROW_W  = 3,
   parameter int DATA_W = 16,
   localparam int ADDR_W = CHIP_W + BANK_W + SUB_W + ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [1:0]        mode_op,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_src_a,
   input  logic [ADDR_W-1:0] req_src_b,
   input  logic [ADDR_W-1:0] req_dst,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [1:0]        scope,
   output logic              sense_en,
   output logic [1:0]        sense_op,
   output logic [ADDR_W-1:0] sense_row_a,
   output logic [ADDR_W-1:0] sense_row_b,
   input  logic [DATA_W-1:0] sense_data,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int NUM_BUF = 2;

   if (CHIP_W < 1 || BANK_W < 1 || SUB_W < 1 || ROW_W < 1) begin : g_bad_addr
      $error("bwsd_scope_dispatch: every address field needs at least one bit");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("bwsd_scope_dispatch: DATA_W must be positive");
   end

   seq_e              state;
   bw_op_e            mode_q, op_q;
   logic [1:0]        scope_q;
   logic [1:0]        cls;
   logic [ADDR_W-1:0] a_q, b_q, d_q;
   logic [DATA_W-1:0] res_q;
   logic              err_q;
   logic [DATA_W-1:0] buf_q [NUM_BUF];

   bwsd_classify #(
      .CHIP_W(CHIP_W), .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W)
   ) u_classify (
      .op   (mode_q),
      .src_a(req_src_a),
      .src_b(req_src_b),
      .scope(cls)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= OP_AND;
         op_q    <= OP_AND;
         scope_q <= SCOPE_ARRAY;
         a_q     <= '0;
         b_q     <= '0;
         d_q     <= '0;
         res_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (mode_wr) mode_q <= bw_op_e'(mode_op);
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (cls == SCOPE_NONE) begin
                     err_q <= 1'b1;
                  end else begin
                     op_q    <= mode_q;
                     scope_q <= cls;
                     a_q     <= req_src_a;
                     b_q     <= req_src_b;
                     d_q     <= req_dst;
                     state   <= (cls == SCOPE_ARRAY) ? ST_SENSE : ST_FETCH_A;
                  end
               end
            end
            ST_SENSE:   state <= ST_CAPT;
            ST_CAPT: begin
               res_q <= sense_data;
               state <= ST_WRITE;
            end
            ST_FETCH_A: state <= ST_FETCH_B;
            ST_FETCH_B: state <= ST_MERGE;
            ST_MERGE:   state <= ST_WRITE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
      logic sel;
      assign sel = scope_q == 2'(g + 1);
      bwsd_stage_buf #(.DATA_W(DATA_W)) u_buf (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (sel && state == ST_FETCH_B),
         .merge (sel && state == ST_MERGE),
         .op    (op_q),
         .bus_in(rd_data),
         .q     (buf_q[g])
      );
   end

   assign busy        = state != ST_IDLE;
   assign done        = state == ST_WRITE;
   assign err         = err_q;
   assign scope       = scope_q;
   assign sense_en    = state == ST_SENSE;
   assign sense_op    = op_q;
   assign sense_row_a = a_q;
   assign sense_row_b = (op_q == OP_INV) ? a_q : b_q;
   assign rd_en       = (state == ST_FETCH_A) || (state == ST_FETCH_B);
   assign rd_addr     = (state == ST_FETCH_A) ? a_q : b_q;
   assign wr_en       = state == ST_WRITE;
   assign wr_addr     = d_q;
   assign wr_data     = (scope_q == SCOPE_ARRAY) ? res_q
                      : (scope_q == SCOPE_BANK)  ? buf_q[1] : buf_q[0];
endmodule

// File: rtl/bwsd_scope_dispatch_chk.sv
module bwsd_scope_dispatch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic [1:0] scope,
   input logic       sense_en,
   input logic       rd_en,
   input logic       wr_en,
   input logic       req_valid
);
   a_r3_sense_only_array: assert property (@(posedge clk) disable iff (!rst_n)
      sense_en |-> scope == 2'd0);

   a_r4_read_only_staged: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (scope == 2'd1 || scope == 2'd2));

   a_r5_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !sense_en && !rd_en && !wr_en);

   a_r8_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      busy && req_valid |=> !err);

   a_r8_scope_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(scope));

   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r9_one_command: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sense_en, rd_en, wr_en}));
endmodule

bind bwsd_scope_dispatch bwsd_scope_dispatch_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .scope    (scope),
   .sense_en (sense_en),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .req_valid(req_valid)
);

// File: tb/tb_bwsd_scope_dispatch.sv
module tb_bwsd_scope_dispatch;
   localparam int AW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_op = 2'd0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
   logic          busy, done, err, sense_en, rd_en, wr_en;
   logic [1:0]    scope, sense_op;
   logic [AW-1:0] sense_row_a, sense_row_b, rd_addr, wr_addr;
   logic [DW-1:0] sense_data, rd_data, wr_data;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int sn_cnt = 0;

   logic [DW-1:0] mem [256];
   logic [DW-1:0] shadow [256];

   always #10 clk = ~clk;

   bwsd_scope_dispatch dut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_op(mode_op),
      .req_valid(req_valid), .req_src_a(req_src_a), .req_src_b(req_src_b),
      .req_dst(req_dst), .busy(busy), .done(done), .err(err), .scope(scope),
      .sense_en(sense_en), .sense_op(sense_op), .sense_row_a(sense_row_a),
      .sense_row_b(sense_row_b), .sense_data(sense_data), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   function automatic logic [DW-1:0] f_op(logic [1:0] op, logic [DW-1:0] x, logic [DW-1:0] y);
      case (op)
         2'd0:    return x & y;
         2'd1:    return x | y;
         2'd2:    return x ^ y;
         default: return ~x;
      endcase
   endfunction

   always @(posedge clk) begin
      if (sense_en) begin
         sense_data <= f_op(sense_op, mem[sense_row_a], mem[sense_row_b]);
         sn_cnt <= sn_cnt + 1;
      end
      if (rd_en) begin
         rd_data <= mem[rd_addr];
         rd_cnt  <= rd_cnt + 1;
      end
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
         wr_cnt <= wr_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] a;
      logic [AW-1:0] b;
      logic [AW-1:0] d;
      logic [1:0]    sc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'h01, 8'h02, 8'h03, 2'd0},
      '{2'd1, 8'h09, 8'h0C, 8'h0D, 2'd0},
      '{2'd2, 8'h11, 8'h16, 8'h17, 2'd0},
      '{2'd0, 8'h01, 8'h0A, 8'h05, 2'd1},
      '{2'd1, 8'h22, 8'h3B, 8'h24, 2'd1},
      '{2'd2, 8'h44, 8'h5D, 8'h46, 2'd1},
      '{2'd0, 8'h01, 8'h21, 8'h06, 2'd2},
      '{2'd2, 8'h63, 8'h13, 8'h60, 2'd2},
      '{2'd1, 8'h0A, 8'h0A, 8'h0B, 2'd3},
      '{2'd0, 8'h02, 8'h82, 8'h07, 2'd3},
      '{2'd3, 8'h0A, 8'h8F, 8'h0E, 2'd0},
      '{2'd3, 8'h33, 8'h33, 8'h34, 2'd0},
      '{2'd2, 8'h25, 8'hA5, 8'h26, 2'd3},
      '{2'd1, 8'h41, 8'h61, 8'h90, 2'd2}
   };

   task automatic set_mode(input logic [1:0] op);
      @(negedge clk);
      mode_wr = 1'b1;
      mode_op = op;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [AW-1:0] b, input logic [AW-1:0] d,
                          input logic [1:0] sc);
      logic [DW-1:0] exp_v;
      int k;
      int rd0, wr0, sn0;
      exp_v = f_op(op, shadow[a], shadow[b]);
      @(negedge clk);
      rd0 = rd_cnt; wr0 = wr_cnt; sn0 = sn_cnt;
      req_valid = 1'b1; req_src_a = a; req_src_b = b; req_dst = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (sc == 2'd3) begin
         chk(err == 1'b1, "R5 err pulse", 32'(err), 1);
         chk(busy == 1'b0, "R5 busy stays low", 32'(busy), 0);
         @(negedge clk);
         chk(err == 1'b0, "R5 err one cycle", 32'(err), 0);
         @(negedge clk);
         chk(rd_cnt == rd0 && wr_cnt == wr0 && sn_cnt == sn0, "R5 no traffic",
             32'(rd_cnt - rd0 + wr_cnt - wr0 + sn_cnt - sn0), 0);
         chk(mem[d] == shadow[d], "R5 dst untouched", 32'(mem[d]), 32'(shadow[d]));
      end else begin
         chk(busy == 1'b1 && err == 1'b0, "R8 busy after accept", 32'({busy, err}), 32'h2);
         chk(scope == sc, "R3 R4 scope", 32'(scope), 32'(sc));
         k = 1;
         while (!done && k < 10) begin
            @(negedge clk);
            k++;
         end
         chk(k == ((sc == 2'd0) ? 3 : 4), "R9 done latency", 32'(k), (sc == 2'd0) ? 3 : 4);
         chk(wr_data == exp_v && wr_addr == d, "R6 write word", 32'(wr_data), 32'(exp_v));
         @(negedge clk);
         chk(busy == 1'b0 && done == 1'b0, "R8 busy ends after write", 32'({busy, done}), 0);
         chk(mem[d] == exp_v, "R6 dst row", 32'(mem[d]), 32'(exp_v));
         if (op == 2'd3 || sc == 2'd0)
            chk(rd_cnt == rd0 && sn_cnt == sn0 + 1, "R3 R7 single sense no reads",
                32'(rd_cnt - rd0), 0);
         else
            chk(rd_cnt == rd0 + 2 && sn_cnt == sn0, "R4 two reads", 32'(rd_cnt - rd0), 2);
         shadow[d] = exp_v;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]    = DW'(i * 16'h9E37) ^ DW'(i << 5) ^ 16'h5A3C;
         shadow[i] = DW'(i * 16'h9E37) ^ DW'(i << 5) ^ 16'h5A3C;
      end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset outputs",
          32'({busy, done, err}), 0);
      chk(scope == 2'd0, "R1 reset scope", 32'(scope), 0);
      rst_n = 1'b1;
      // R1 R2: default mode AND without any mode write
      run_req(2'd0, 8'h29, 8'h2E, 8'h2F, 2'd0);

      for (int v = 0; v < NV; v++) begin
         set_mode(VEC[v].op);
         run_req(VEC[v].op, VEC[v].a, VEC[v].b, VEC[v].d, VEC[v].sc);
      end

      // R8: mode write and a refusable request while busy have no effect
      set_mode(2'd1);
      @(negedge clk);
      req_valid = 1'b1; req_src_a = 8'h03; req_src_b = 8'h4B; req_dst = 8'h70;
      @(negedge clk);
      req_valid = 1'b0;
      mode_wr = 1'b1; mode_op = 2'd2;
      req_src_a = 8'h55; req_src_b = 8'h55; req_dst = 8'h71;
      @(negedge clk);
      mode_wr = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(err == 1'b0, "R8 no err while busy", 32'(err), 0);
      while (!done) @(negedge clk);
      chk(wr_data == (shadow[8'h03] | shadow[8'h4B]), "R8 op latched at accept",
          32'(wr_data), 32'(shadow[8'h03] | shadow[8'h4B]));
      shadow[8'h70] = shadow[8'h03] | shadow[8'h4B];
      @(negedge clk);
      chk(mem[8'h71] == shadow[8'h71], "R8 busy request dropped",
          32'(mem[8'h71]), 32'(shadow[8'h71]));
      // R2: the mode written during busy applies to the next request
      run_req(2'd2, 8'h0B, 8'h0F, 8'h08, 2'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule